// File: doc/BRIEF.md
# Thread-Ranked Bank Request Scheduler

This block sits in front of a single DRAM bank. It holds the memory requests queued for that bank, each tagged with the thread that issued it. In every service slot it picks one of them to send to the bank. Each bank of a multi-bank controller has its own copy of the block. Each copy decides alone, using only its own buffer. Because a thread stays stalled until its last outstanding request anywhere has been served, the block can finish each thread's requests as a group rather than spreading them across time. This shortens average thread stall time.

Three selection policies are available, chosen by a mode input:

- **Arrival-order baseline.** Requests are served strictly in the order they arrived.
- **Shared ranking.** A per-thread priority vector, common to all banks, decides the order. All requests of a better-ranked thread leave before any request of a worse-ranked one.
- **Local fairness.** The block ranks threads by how many requests each still has pending here, fewest first, without regard to the numeric thread identifier.

Ties are broken by age, so every choice is deterministic. Per-thread pending counts are exported so that neighbouring logic can observe the load. Each request occupies exactly one service slot, and the bank accepts at most one request per clock on a valid/ready handshake.

Top module: `bank_rank_sched`

## Requirements
- R1: After reset the buffer is empty: `srv_valid` is 0, `enq_ready` is 1 and every pending count is 0.
- R2: With `sched_mode` = 0 (or 3), requests leave in the exact order they were accepted.
- R3: With `sched_mode` = 1, the request served is the oldest one belonging to the thread whose priority field is numerically smallest. Thread t's priority occupies bits [t*RANKW +: RANKW] of `rank_in`. Threads with equal priority are resolved in favour of the oldest request. A change of `rank_in` applies to the very next selection.
- R4: With `sched_mode` = 2, the request served is the oldest one of the thread with the fewest pending requests in this buffer. Ties go to the oldest request, whatever the thread identifiers are.
- R5: The buffer holds DEPTH requests. When it is full, `enq_ready` is 0 and an offered request is dropped without changing any pending count.
- R6: Pending count t (bits [t*CW +: CW] of `pend_cnt`, CW = clog2(DEPTH+1)) equals the number of buffered requests of thread t. It rises by one on each accepted enqueue of thread t and falls by one on each service of thread t.
- R7: A request is removed only on a cycle where `srv_valid` and `srv_ready` are both 1. At most one request leaves per cycle. While `srv_ready` is low, with no enqueue and unchanged mode and ranking, the offered request stays the same.
- R8: For a two-bank, four-thread load whose per-thread completion slots are 4, 4, 5 and 7 under arrival order, the shared ranking (thread 0 best) yields completion slots 1, 2, 4 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_mode | input | 2 | 0/3 arrival order, 1 shared ranking, 2 local fewest-pending |
| rank_in | input | NTHR*RANKW | Per-thread priority, smaller value served first |
| enq_valid | input | 1 | Request offered |
| enq_ready | output | 1 | Buffer has room |
| enq_thread | input | clog2(NTHR) | Issuing thread of the offered request |
| enq_tag | input | TAGW | Opaque request tag |
| srv_valid | output | 1 | A request is offered to the bank |
| srv_ready | input | 1 | Bank takes the offered request this cycle |
| srv_thread | output | clog2(NTHR) | Thread of the offered request |
| srv_tag | output | TAGW | Tag of the offered request |
| pend_cnt | output | NTHR*clog2(DEPTH+1) | Per-thread pending counts |

## Verification
The assertions assume that the stimulus never holds `rst_n` high before the first edge. They also assume that the enqueue side respects `enq_ready`, so the occupancy never passes DEPTH, and that tags in the buffer are distinct, so that a held offer can be recognised by its tag. The stimulus resets the block at time zero. It issues tags from a running counter that wraps far beyond DEPTH and lets the bench's own occupancy model decide whether an offer is accepted. Long pseudo-random runs in each mode, with the ranking reshuffled every few cycles and simultaneous enqueue and service, are compared slot by slot against an arithmetic model of the three policies.

// File: rtl/sched_pkg.sv
package sched_pkg;

   typedef enum logic [1:0] {
      SCH_ARRIVAL = 2'd0,
      SCH_RANKED  = 2'd1,
      SCH_FEWEST  = 2'd2,
      SCH_ALT     = 2'd3
   } sched_mode_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sched_req_store.sv
module sched_req_store #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned TW    = 3,
   parameter int unsigned GW    = 8,
   localparam int unsigned IW   = $clog2(DEPTH),
   localparam int unsigned OW   = $clog2(DEPTH + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push_i,
   input  logic [TW-1:0]                push_thr_i,
   input  logic [GW-1:0]                push_tag_i,
   input  logic                         pop_i,
   input  logic [IW-1:0]                pop_idx_i,
   output logic [DEPTH-1:0]             vld_o,
   output logic [DEPTH-1:0][TW-1:0]     thr_o,
   output logic [DEPTH-1:0][GW-1:0]     tag_o,
   output logic [OW-1:0]                occ_o
);

   logic [DEPTH-1:0]         vld_q, vld_sh, vld_n;
   logic [DEPTH-1:0][TW-1:0] thr_q, thr_sh, thr_n;
   logic [DEPTH-1:0][GW-1:0] tag_q, tag_sh, tag_n;
   logic [OW-1:0]            occ_q, occ_n, tail;

   // Entry 0 is always the oldest: removal closes the gap by shifting.
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic moves;
      assign moves = pop_i && (pop_idx_i <= IW'(g));
      if (g == DEPTH - 1) begin : g_last
         assign vld_sh[g] = moves ? 1'b0 : vld_q[g];
         assign thr_sh[g] = moves ? '0 : thr_q[g];
         assign tag_sh[g] = moves ? '0 : tag_q[g];
      end else begin : g_mid
         assign vld_sh[g] = moves ? vld_q[g+1] : vld_q[g];
         assign thr_sh[g] = moves ? thr_q[g+1] : thr_q[g];
         assign tag_sh[g] = moves ? tag_q[g+1] : tag_q[g];
      end
   end

   always_comb begin
      vld_n = vld_sh;
      thr_n = thr_sh;
      tag_n = tag_sh;
      tail  = occ_q - OW'(pop_i);
      if (push_i) begin
         vld_n[tail[IW-1:0]] = 1'b1;
         thr_n[tail[IW-1:0]] = push_thr_i;
         tag_n[tail[IW-1:0]] = push_tag_i;
      end
      occ_n = occ_q + OW'(push_i) - OW'(pop_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         thr_q <= '0;
         tag_q <= '0;
         occ_q <= '0;
      end else begin
         vld_q <= vld_n;
         thr_q <= thr_n;
         tag_q <= tag_n;
         occ_q <= occ_n;
      end
   end

   assign vld_o = vld_q;
   assign thr_o = thr_q;
   assign tag_o = tag_q;
   assign occ_o = occ_q;

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OW'(DEPTH))
      else $error("occupancy beyond depth");

   p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> vld_q[pop_idx_i])
      else $error("removal of an empty slot");

endmodule

// File: rtl/sched_thread_counters.sv
module sched_thread_counters #(
   parameter int unsigned NTHR = 8,
   parameter int unsigned CW   = 5,
   localparam int unsigned TW  = $clog2(NTHR)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     inc_i,
   input  logic [TW-1:0]            inc_thr_i,
   input  logic                     dec_i,
   input  logic [TW-1:0]            dec_thr_i,
   output logic [NTHR-1:0][CW-1:0]  cnt_o
);

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      logic          up, dn;
      logic [CW-1:0] cnt_q;
      assign up = inc_i && (inc_thr_i == TW'(t));
      assign dn = dec_i && (dec_thr_i == TW'(t));
      always_ff @(posedge clk) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= cnt_q + CW'(up) - CW'(dn);
      end
      assign cnt_o[t] = cnt_q;

      p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (dn && !up) |-> (cnt_q != '0))
         else $error("pending count underflow");
   end

endmodule

// File: rtl/sched_pick.sv
module sched_pick
   import sched_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned NTHR  = 8,
   parameter int unsigned RANKW = 3,
   parameter int unsigned CW    = 5,
   localparam int unsigned TW   = $clog2(NTHR),
   localparam int unsigned IW   = $clog2(DEPTH),
   localparam int unsigned KW   = max_of(RANKW, CW)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  sched_mode_e                 mode_i,
   input  logic [NTHR*RANKW-1:0]       rank_i,
   input  logic [NTHR-1:0][CW-1:0]     cnt_i,
   input  logic [DEPTH-1:0]            vld_i,
   input  logic [DEPTH-1:0][TW-1:0]    thr_i,
   output logic                        any_o,
   output logic [IW-1:0]               sel_o
);

   logic [DEPTH-1:0][KW-1:0] key;

   for (genvar g = 0; g < DEPTH; g++) begin : g_key
      logic [RANKW-1:0] rank_of;
      logic [CW-1:0]    load_of;
      assign rank_of = rank_i[thr_i[g]*RANKW +: RANKW];
      assign load_of = cnt_i[thr_i[g]];
      always_comb begin
         unique case (mode_i)
            SCH_RANKED: key[g] = KW'(rank_of);
            SCH_FEWEST: key[g] = KW'(load_of);
            default:    key[g] = '0;
         endcase
      end
   end

   // Strict less-than on an age-ordered scan: equal keys keep the oldest.
   always_comb begin
      logic [KW-1:0] best;
      best  = '0;
      any_o = 1'b0;
      sel_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (vld_i[i] && (!any_o || key[i] < best)) begin
            best  = key[i];
            sel_o = IW'(i);
            any_o = 1'b1;
         end
      end
   end

   p_sel_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> vld_i[sel_o])
      else $error("selected slot is empty");

endmodule

// File: rtl/bank_rank_sched.sv
module bank_rank_sched
   import sched_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned NTHR  = 8,
   parameter int unsigned RANKW = 3,
   parameter int unsigned TAGW  = 8,
   localparam int unsigned TW   = $clog2(NTHR),
   localparam int unsigned CW   = $clog2(DEPTH + 1),
   localparam int unsigned IW   = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             sched_mode,
   input  logic [NTHR*RANKW-1:0]  rank_in,
   input  logic                   enq_valid,
   output logic                   enq_ready,
   input  logic [TW-1:0]          enq_thread,
   input  logic [TAGW-1:0]        enq_tag,
   output logic                   srv_valid,
   input  logic                   srv_ready,
   output logic [TW-1:0]          srv_thread,
   output logic [TAGW-1:0]        srv_tag,
   output logic [NTHR*CW-1:0]     pend_cnt
);

   initial begin
      if (DEPTH < 2)  $fatal(1, "DEPTH must be at least 2");
      if (NTHR < 2)   $fatal(1, "NTHR must be at least 2");
      if (RANKW < 1)  $fatal(1, "RANKW must be at least 1");
      if (TAGW < 1)   $fatal(1, "TAGW must be at least 1");
   end

   sched_mode_e               mode;
   logic [DEPTH-1:0]          vld;
   logic [DEPTH-1:0][TW-1:0]  thr;
   logic [DEPTH-1:0][TAGW-1:0] tag;
   logic [CW-1:0]             occ;
   logic [NTHR-1:0][CW-1:0]   cnt;
   logic                      any;
   logic [IW-1:0]             sel;
   logic                      enq_fire, srv_fire;

   assign mode      = sched_mode_e'(sched_mode);
   assign enq_ready = (occ != CW'(DEPTH));
   assign enq_fire  = enq_valid && enq_ready;
   assign srv_valid = any;
   assign srv_fire  = any && srv_ready;
   assign srv_thread = thr[sel];
   assign srv_tag    = tag[sel];
   assign pend_cnt   = cnt;

   sched_req_store #(.DEPTH(DEPTH), .TW(TW), .GW(TAGW)) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (enq_fire),
      .push_thr_i (enq_thread),
      .push_tag_i (enq_tag),
      .pop_i      (srv_fire),
      .pop_idx_i  (sel),
      .vld_o      (vld),
      .thr_o      (thr),
      .tag_o      (tag),
      .occ_o      (occ)
   );

   sched_thread_counters #(.NTHR(NTHR), .CW(CW)) i_counts (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (enq_fire),
      .inc_thr_i (enq_thread),
      .dec_i     (srv_fire),
      .dec_thr_i (srv_thread),
      .cnt_o     (cnt)
   );

   sched_pick #(.DEPTH(DEPTH), .NTHR(NTHR), .RANKW(RANKW), .CW(CW)) i_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode),
      .rank_i (rank_in),
      .cnt_i  (cnt),
      .vld_i  (vld),
      .thr_i  (thr),
      .any_o  (any),
      .sel_o  (sel)
   );

   logic [CW+TW-1:0] cnt_sum;
   always_comb begin
      cnt_sum = '0;
      for (int t = 0; t < NTHR; t++) cnt_sum = cnt_sum + (CW+TW)'(cnt[t]);
   end

   p_count_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_sum == (CW+TW)'(occ))
      else $error("pending counts disagree with occupancy");

   p_offer_has_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      srv_valid |-> (cnt[srv_thread] != '0))
      else $error("offered thread has no pending count");

   p_hold_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(srv_valid && !srv_ready && !enq_fire) && $stable(sched_mode) && $stable(rank_in))
      |-> (srv_valid && $stable(srv_tag) && $stable(srv_thread)))
      else $error("offer changed while stalled");

endmodule

// File: tb/test_bank_rank_sched.sv
module test_bank_rank_sched;

   localparam int DEPTH = 16;
   localparam int NTHR  = 8;
   localparam int RANKW = 3;
   localparam int TAGW  = 8;
   localparam int TW    = $clog2(NTHR);
   localparam int CW    = $clog2(DEPTH + 1);

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [1:0]            sched_mode = 2'd0;
   logic [NTHR*RANKW-1:0] rank_in = '0;
   logic                  enq_valid = 1'b0;
   logic                  enq_ready;
   logic [TW-1:0]         enq_thread = '0;
   logic [TAGW-1:0]       enq_tag = '0;
   logic                  srv_valid;
   logic                  srv_ready = 1'b0;
   logic [TW-1:0]         srv_thread;
   logic [TAGW-1:0]       srv_tag;
   logic [NTHR*CW-1:0]    pend_cnt;

   always #2 clk = ~clk;

   bank_rank_sched #(.DEPTH(DEPTH), .NTHR(NTHR), .RANKW(RANKW), .TAGW(TAGW)) i_bank_rank_sched (
      .clk, .rst_n, .sched_mode, .rank_in, .enq_valid, .enq_ready, .enq_thread,
      .enq_tag, .srv_valid, .srv_ready, .srv_thread, .srv_tag, .pend_cnt
   );

   int n_cmp = 0, n_bad = 0;
   int m_thr[DEPTH], m_tag[DEPTH], m_n = 0;
   int rk[NTHR];
   int tag_ctr = 0;
   int slot = 0;
   int last_thr = -1;
   bit lfsr_init = 0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
      end
   endtask

   function automatic int mdl_count(input int t);
      int c = 0;
      for (int i = 0; i < m_n; i++) if (m_thr[i] == t) c++;
      return c;
   endfunction

   function automatic int mdl_pick();
      int best = 0, bk = 0, k;
      for (int i = 0; i < m_n; i++) begin
         case (sched_mode)
            2'd1:    k = rk[m_thr[i]];
            2'd2:    k = mdl_count(m_thr[i]);
            default: k = 0;
         endcase
         if (i == 0 || k < bk) begin best = i; bk = k; end
      end
      return best;
   endfunction

   function automatic string mode_req();
      case (sched_mode)
         2'd1:    return "R3";
         2'd2:    return "R4";
         default: return "R2";
      endcase
   endfunction

   task automatic drive_ranks();
      for (int t = 0; t < NTHR; t++) rank_in[t*RANKW +: RANKW] = RANKW'(rk[t]);
   endtask

   task automatic check_counts();
      for (int t = 0; t < NTHR; t++)
         chk(int'(pend_cnt[t*CW +: CW]) == mdl_count(t), "R6",
             int'(pend_cnt[t*CW +: CW]), mdl_count(t));
   endtask

   // Called just after a falling edge; returns just after the next falling edge.
   task automatic cycle(input bit ev, input int et, input bit sr);
      int pick;
      bit had;
      enq_valid  = ev;
      enq_thread = TW'(et);
      enq_tag    = TAGW'(tag_ctr);
      srv_ready  = sr;
      #1;
      chk(srv_valid == (m_n > 0), "R7", srv_valid, m_n > 0);
      chk(enq_ready == (m_n < DEPTH), "R5", enq_ready, m_n < DEPTH);
      had  = (m_n > 0);
      pick = had ? mdl_pick() : 0;
      last_thr = -1;
      if (sr && had) begin
         chk(int'(srv_thread) == m_thr[pick], mode_req(), srv_thread, m_thr[pick]);
         chk(int'(srv_tag) == m_tag[pick], mode_req(), srv_tag, m_tag[pick]);
      end
      @(posedge clk);
      begin
         bit acc = ev && (m_n < DEPTH);
         if (sr && had) begin
            last_thr = m_thr[pick];
            for (int i = pick; i < m_n - 1; i++) begin
               m_thr[i] = m_thr[i+1];
               m_tag[i] = m_tag[i+1];
            end
            m_n--;
         end
         if (acc) begin
            m_thr[m_n] = et;
            m_tag[m_n] = tag_ctr % 256;
            m_n++;
            tag_ctr++;
         end
      end
      @(negedge clk);
      enq_valid = 1'b0;
      srv_ready = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      enq_valid = 1'b0;
      srv_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_n = 0;
      #1;
      chk(srv_valid == 1'b0, "R1", srv_valid, 0);
      chk(enq_ready == 1'b1, "R1", enq_ready, 1);
      chk(pend_cnt == '0, "R1", int'(pend_cnt != '0), 0);
      @(negedge clk);
   endtask

   function automatic int rnd(input int m);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return int'(lfsr[15:0]) % m;
   endfunction

   // Two-bank load for R8: arrival lists per bank.
   int bank0[7] = '{3, 1, 2, 0, 2, 3, 3};
   int bank1[4] = '{3, 2, 0, 1};

   task automatic run_load(input bit [1:0] md, output int comp[4]);
      for (int t = 0; t < 4; t++) comp[t] = 0;
      sched_mode = md;
      for (int b = 0; b < 2; b++) begin
         int len = (b == 0) ? 7 : 4;
         for (int i = 0; i < len; i++) cycle(1'b1, (b == 0) ? bank0[i] : bank1[i], 1'b0);
         slot = 0;
         while (m_n > 0) begin
            cycle(1'b0, 0, 1'b1);
            slot++;
            if (last_thr >= 0 && last_thr < 4 && comp[last_thr] < slot) comp[last_thr] = slot;
         end
      end
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int cf[4], cr[4];
      for (int t = 0; t < NTHR; t++) rk[t] = t;
      drive_ranks();
      @(negedge clk);
      do_reset();   // R1

      // R5 / R6 / R7: fill, overfill, stall, drain in arrival order (R2)
      sched_mode = 2'd0;
      for (int i = 0; i < DEPTH; i++) cycle(1'b1, (i * 3) % NTHR, 1'b0);
      check_counts();
      chk(enq_ready == 1'b0, "R5", enq_ready, 0);
      cycle(1'b1, 5, 1'b0);
      check_counts();
      begin
         logic [TAGW-1:0] held = srv_tag;
         cycle(1'b0, 0, 1'b0);
         cycle(1'b0, 0, 1'b0);
         chk(srv_tag == held, "R7", srv_tag, held);
         chk(int'(held) == 0, "R2", held, 0);
      end
      while (m_n > 0) cycle(1'b0, 0, 1'b1);
      check_counts();

      // Sweep every mode (including the alias 3) with reshuffled rankings
      for (int md = 0; md < 4; md++) begin
         do_reset();
         sched_mode = 2'(md);
         for (int c = 0; c < 1500; c++) begin
            if (c % 5 == 0) begin
               for (int t = 0; t < NTHR; t++) rk[t] = rnd(1 << RANKW);
               drive_ranks();
            end
            cycle(rnd(4) != 0, rnd(NTHR), rnd(3) == 0);
            if (c % 97 == 0) check_counts();
         end
         while (m_n > 0) cycle(1'b0, 0, 1'b1);
         check_counts();
      end

      // R8: arrival order vs shared ranking (thread 0 best)
      for (int t = 0; t < NTHR; t++) rk[t] = t;
      drive_ranks();
      do_reset();
      run_load(2'd0, cf);
      run_load(2'd1, cr);
      chk(cf[0] == 4 && cf[1] == 4 && cf[2] == 5 && cf[3] == 7, "R8",
          cf[0] + cf[1] + cf[2] + cf[3], 20);
      chk(cr[0] == 1 && cr[1] == 2 && cr[2] == 4 && cr[3] == 7, "R8",
          cr[0] + cr[1] + cr[2] + cr[3], 14);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule